// File: doc/BRIEF.md
# Prescaled Auto-Reload Up-Counter Peripheral

This block is a general-purpose up-counting timer on a simple 32-bit register bus. The bus has a byte address, a write enable, write data and combinational read data. A divider turns the input clock into count ticks at a rate of clock / (divisor + 1). The counter steps once per tick while the run bit is set. When the counter holds the reload value on a tick, it returns to zero on that tick. In the same cycle it raises a sticky update flag and a one-cycle interrupt pulse, provided the update interrupt is enabled.

Software can load the counter directly, force it to zero with an event write, or change the divisor. Each of these restarts the tick phase, and a divisor change leaves the current count as it is. A reload value of zero disables update events. Seven further words hold compare and auxiliary settings as plain storage. Every other offset in the 0x400-byte window reads as zero and ignores writes.

Word offsets:

| Offset | Register |
|---|---|
| 0x00 | control (bit 0 = run) |
| 0x0C | interrupt enable (bit 0) |
| 0x10 | status (bit 0 = update flag) |
| 0x14 | event (bit 0 = zero the counter) |
| 0x24 | counter |
| 0x28 | divisor |
| 0x2C | reload |
| 0x34–0x40 | compare 1–4 |
| 0x48, 0x4C, 0x50 | auxiliary storage |

Top module: `tmr_top`

## Requirements
- R1: After a synchronous active-high reset, every register reads 0, including the counter, and the interrupt output is low.
- R2: With run set and divisor D, the counter increases by one exactly once every D+1 clock cycles.
- R3: A divisor write keeps only bits 15:0; the upper read bits of offset 0x28 are 0.
- R4: A divisor write leaves the counter value unchanged. The next tick then comes D_new+1 cycles after the write edge.
- R5: On a tick where the counter equals a non-zero reload value, the counter becomes 0 instead of incrementing.
- R6: While the reload value is 0, no update flag is set and no interrupt pulse is issued.
- R7: On a wrap with interrupt-enable bit 0 set, status bit 0 is set and the interrupt output is high for exactly the next cycle. Without that enable bit, neither happens.
- R8: A status write performs status = status AND data. Writing 1 to bit 0 leaves it unchanged, and writing 0 clears it.
- R9: An event write with bit 0 set forces the counter to 0 and restarts the tick phase. The written value reads back at 0x14.
- R10: A counter write loads the counter with the written value and restarts the tick phase.
- R11: Reads of unmapped or misaligned addresses return 0, and writes to them change no register.
- R12: The compare and auxiliary words (0x34, 0x38, 0x3C, 0x40, 0x48, 0x4C, 0x50) read back the last value written to each.
- R13: While run (control bit 0) is clear, the counter does not change except through R9 or R10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 10 | Byte address within the window |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for bus_addr |
| irq | output | 1 | One-cycle update interrupt pulse |

## Verification
The in-line properties check on every cycle that:
- the interrupt is never wider than one cycle and always coincides with a set flag;
- a reload of zero never yields a pulse;
- loads, event writes and divisor writes land in the counter and divisor on the following edge;
- the counter holds still without a tick.

Only the bench scenarios can show that the tick spacing matches the divisor over long runs, that the phase restarts after a divisor change while the count is kept, and that unmapped accesses leave every register untouched. The bench shows these by comparing read data and the interrupt line against a cycle model built from the requirements.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    localparam int ADDR_W    = 10;
    localparam int IDX_W     = ADDR_W - 2;
    localparam int DATA_W    = 32;
    localparam int DIV_W     = 16;
    localparam int NUM_STORE = 7;

    localparam logic [IDX_W-1:0] OFS_CTRL = 8'h00;
    localparam logic [IDX_W-1:0] OFS_IEN  = 8'h03;
    localparam logic [IDX_W-1:0] OFS_STAT = 8'h04;
    localparam logic [IDX_W-1:0] OFS_EVG  = 8'h05;
    localparam logic [IDX_W-1:0] OFS_CNT  = 8'h09;
    localparam logic [IDX_W-1:0] OFS_DIV  = 8'h0A;
    localparam logic [IDX_W-1:0] OFS_RLD  = 8'h0B;
    localparam logic [IDX_W-1:0] OFS_CMP0 = 8'h0D;
    localparam logic [IDX_W-1:0] OFS_AUX0 = 8'h12;

    typedef struct packed {
        logic              we;
        logic              aligned;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] data;
    } bus_req_t;

    typedef struct packed {
        logic              load;
        logic [DATA_W-1:0] value;
    } cnt_load_t;

    function automatic logic [IDX_W-1:0] store_word(input int slot);
        return (slot < 4) ? IDX_W'(int'(OFS_CMP0) + slot)
                          : IDX_W'(int'(OFS_AUX0) + slot - 4);
    endfunction

    function automatic logic hits(input bus_req_t r, input logic [IDX_W-1:0] ofs);
        return r.we && r.aligned && (r.idx == ofs);
    endfunction
endpackage

// File: rtl/tmr_tick_gen.sv
module tmr_tick_gen
    import tmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             restart,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    logic [DIV_W-1:0] phase_q;

    assign tick = run && !restart && (phase_q == div);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            phase_q <= '0;
        end else if (run) begin
            phase_q <= (phase_q == div) ? '0 : phase_q + 1'b1;
        end
    end

    p_phase_bound_r2: assert property (@(posedge clk) disable iff (rst)
        phase_q <= div);
    p_phase_frozen_r13: assert property (@(posedge clk) disable iff (rst)
        (!run && !restart) |=> $stable(phase_q));
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  cnt_load_t         ld,
    input  logic [DATA_W-1:0] reload,
    output logic [DATA_W-1:0] cnt,
    output logic              wrap
);
    assign wrap = tick && (reload != '0) && (cnt == reload);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (ld.load) begin
            cnt <= ld.value;
        end else if (wrap) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= cnt + 1'b1;
        end
    end

    p_wrap_zero_r5: assert property (@(posedge clk) disable iff (rst)
        (wrap && !ld.load) |=> (cnt == '0));
    p_step_r2: assert property (@(posedge clk) disable iff (rst)
        (tick && !wrap && !ld.load) |=> (cnt == $past(cnt) + 1'b1));
    p_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (!tick && !ld.load) |=> $stable(cnt));
endmodule

// File: rtl/tmr_regbank.sv
module tmr_regbank
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  bus_req_t          req,
    input  logic [DATA_W-1:0] cnt,
    input  logic              wrap,
    output logic              run,
    output logic [DIV_W-1:0]  div,
    output logic [DATA_W-1:0] reload,
    output logic              restart,
    output cnt_load_t         ld,
    output logic [DATA_W-1:0] rdata,
    output logic              irq
);
    logic [DATA_W-1:0] ctrl_q, ien_q, evg_q, rld_q;
    logic [DIV_W-1:0]  div_q;
    logic              flag_q, irq_q;
    logic [DATA_W-1:0] store_q [NUM_STORE];
    logic              force_zero, fire;

    assign force_zero = hits(req, OFS_EVG) && req.data[0];
    assign ld.load    = hits(req, OFS_CNT) || force_zero;
    assign ld.value   = hits(req, OFS_CNT) ? req.data : '0;
    assign restart    = ld.load || hits(req, OFS_DIV);
    assign fire       = wrap && ien_q[0];
    assign run        = ctrl_q[0];
    assign div        = div_q;
    assign reload     = rld_q;
    assign irq        = irq_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0; ien_q <= '0; evg_q <= '0; rld_q <= '0;
            div_q  <= '0; flag_q <= 1'b0; irq_q <= 1'b0;
        end else begin
            if (hits(req, OFS_CTRL)) ctrl_q <= req.data;
            if (hits(req, OFS_IEN))  ien_q  <= req.data;
            if (hits(req, OFS_EVG))  evg_q  <= req.data;
            if (hits(req, OFS_RLD))  rld_q  <= req.data;
            if (hits(req, OFS_DIV))  div_q  <= req.data[DIV_W-1:0];
            flag_q <= (hits(req, OFS_STAT) ? (flag_q & req.data[0]) : flag_q) | fire;
            irq_q  <= fire;
        end
    end

    for (genvar s = 0; s < NUM_STORE; s++) begin : g_store
        always_ff @(posedge clk) begin
            if (rst) store_q[s] <= '0;
            else if (hits(req, store_word(s))) store_q[s] <= req.data;
        end
    end

    always_comb begin
        rdata = '0;
        if (req.aligned) begin
            case (req.idx)
                OFS_CTRL: rdata = ctrl_q;
                OFS_IEN:  rdata = ien_q;
                OFS_STAT: rdata = DATA_W'(flag_q);
                OFS_EVG:  rdata = evg_q;
                OFS_CNT:  rdata = cnt;
                OFS_DIV:  rdata = DATA_W'(div_q);
                OFS_RLD:  rdata = rld_q;
                default: begin
                    for (int s = 0; s < NUM_STORE; s++)
                        if (req.idx == store_word(s)) rdata = store_q[s];
                end
            endcase
        end
    end

    p_irq_pulse_r7: assert property (@(posedge clk) disable iff (rst)
        irq_q |=> !irq_q);
    p_irq_flag_r7: assert property (@(posedge clk) disable iff (rst)
        irq_q |-> flag_q);
    p_stat_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (hits(req, OFS_STAT) && !req.data[0] && !fire) |=> !flag_q);
    p_stat_keep_r8: assert property (@(posedge clk) disable iff (rst)
        (hits(req, OFS_STAT) && req.data[0] && flag_q) |=> flag_q);
    p_div_mask_r3: assert property (@(posedge clk) disable iff (rst)
        hits(req, OFS_DIV) |=> (div_q == $past(req.data[DIV_W-1:0])));
endmodule

// File: rtl/tmr_top.sv
module tmr_top
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              irq
);
    bus_req_t          req;
    cnt_load_t         ld;
    logic              run, restart, tick, wrap;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] reload, cnt;

    assign req.we      = bus_we;
    assign req.aligned = (bus_addr[1:0] == 2'b00);
    assign req.idx     = bus_addr[ADDR_W-1:2];
    assign req.data    = bus_wdata;

    tmr_regbank u_regs (
        .clk(clk), .rst(rst), .req(req), .cnt(cnt), .wrap(wrap),
        .run(run), .div(div), .reload(reload), .restart(restart),
        .ld(ld), .rdata(bus_rdata), .irq(irq)
    );

    tmr_tick_gen u_tick (
        .clk(clk), .rst(rst), .run(run), .restart(restart),
        .div(div), .tick(tick)
    );

    tmr_count_core u_core (
        .clk(clk), .rst(rst), .tick(tick), .ld(ld),
        .reload(reload), .cnt(cnt), .wrap(wrap)
    );

    p_reload_zero_r6: assert property (@(posedge clk) disable iff (rst)
        (reload == '0) |=> !irq);
    p_evg_zero_r9: assert property (@(posedge clk) disable iff (rst)
        (hits(req, OFS_EVG) && bus_wdata[0] && !hits(req, OFS_CNT)) |=> (cnt == '0));
    p_cnt_load_r10: assert property (@(posedge clk) disable iff (rst)
        hits(req, OFS_CNT) |=> (cnt == $past(bus_wdata)));
    p_idle_r13: assert property (@(posedge clk) disable iff (rst)
        (!run && !ld.load) |=> $stable(cnt));
endmodule

// File: tb/tmr_top_tb_top.sv
module tmr_top_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;
    int          n_total = 0, n_bad = 0;
    logic        irq_watch = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr_top dut_i (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    // Reference model built from the requirements
    logic [31:0] m_ctrl, m_ien, m_evg, m_cnt, m_rld;
    logic [15:0] m_div, m_ph;
    logic        m_flag, m_irq;
    logic [31:0] m_store [7];

    function automatic int slot_of(input logic [9:0] a);
        case (a)
            10'h034: return 0;  10'h038: return 1;  10'h03C: return 2;
            10'h040: return 3;  10'h048: return 4;  10'h04C: return 5;
            10'h050: return 6;  default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] model_read(input logic [9:0] a);
        case (a)
            10'h000: return m_ctrl;
            10'h00C: return m_ien;
            10'h010: return {31'b0, m_flag};
            10'h014: return m_evg;
            10'h024: return m_cnt;
            10'h028: return {16'b0, m_div};
            10'h02C: return m_rld;
            default: return (slot_of(a) >= 0) ? m_store[slot_of(a)] : 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        logic ug, lc, ldv, rs, tk, wr_, fire;
        if (rst) begin
            m_ctrl <= 0; m_ien <= 0; m_evg <= 0; m_cnt <= 0; m_rld <= 0;
            m_div <= 0; m_ph <= 0; m_flag <= 0; m_irq <= 0;
            for (int i = 0; i < 7; i++) m_store[i] <= 0;
        end else begin
            ug   = bus_we && bus_addr == 10'h014 && bus_wdata[0];
            lc   = bus_we && bus_addr == 10'h024;
            ldv  = bus_we && bus_addr == 10'h028;
            rs   = ug || lc || ldv;
            tk   = m_ctrl[0] && !rs && (m_ph == m_div);
            wr_  = tk && m_rld != 0 && m_cnt == m_rld;
            fire = wr_ && m_ien[0];
            if (lc) m_cnt <= bus_wdata;
            else if (ug || wr_) m_cnt <= 0;
            else if (tk) m_cnt <= m_cnt + 1;
            if (rs) m_ph <= 0;
            else if (m_ctrl[0]) m_ph <= (m_ph == m_div) ? 16'h0 : m_ph + 1;
            m_flag <= ((bus_we && bus_addr == 10'h010) ? (m_flag & bus_wdata[0]) : m_flag) | fire;
            m_irq <= fire;
            if (bus_we) begin
                case (bus_addr)
                    10'h000: m_ctrl <= bus_wdata;
                    10'h00C: m_ien <= bus_wdata;
                    10'h014: m_evg <= bus_wdata;
                    10'h028: m_div <= bus_wdata[15:0];
                    10'h02C: m_rld <= bus_wdata;
                    default: if (slot_of(bus_addr) >= 0) m_store[slot_of(bus_addr)] <= bus_wdata;
                endcase
            end
        end
    end

    always @(negedge clk) begin
        if (irq_watch && !rst) begin
            n_total++;
            if (irq !== m_irq) begin
                n_bad++;
                $display("FAIL R7 irq: actual=%0b expected=%0b", irq, m_irq);
            end
        end
    end

    task automatic do_write(input logic [9:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic chk_read(input logic [9:0] a, input string tag);
        logic [31:0] exp;
        @(negedge clk);
        bus_we = 1'b0; bus_addr = a;
        #1;
        exp = model_read(a);
        n_total++;
        if (bus_rdata !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h: actual=%h expected=%h", tag, a, bus_rdata, exp);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_total++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end

    initial begin
        logic [9:0] all_regs [14] = '{10'h000, 10'h00C, 10'h010, 10'h014, 10'h024,
            10'h028, 10'h02C, 10'h034, 10'h038, 10'h03C, 10'h040, 10'h048, 10'h04C, 10'h050};
        logic [9:0] holes [5] = '{10'h004, 10'h018, 10'h030, 10'h3FC, 10'h025};
        void'($urandom(32'd1234));
        idle(3);
        @(negedge clk); rst = 1'b0;
        irq_watch = 1'b1;
        // R1: reset state
        for (int i = 0; i < 14; i++) chk_read(all_regs[i], "R1 reset");
        // R3: divisor keeps low 16 bits
        do_write(10'h028, 32'hFFFF_0002);
        chk_read(10'h028, "R3 divisor mask");
        // R6: reload zero, running with interrupt enabled
        do_write(10'h00C, 32'h1);
        do_write(10'h000, 32'h1);
        idle(60);
        chk_read(10'h010, "R6 no flag");
        chk_read(10'h024, "R2 count rate");
        // R5/R7: wrap at reload 4, divisor 0
        do_write(10'h028, 32'h0);
        do_write(10'h024, 32'h0);
        do_write(10'h02C, 32'h4);
        idle(7);
        chk_read(10'h010, "R7 flag set");
        chk_read(10'h024, "R5 wrapped");
        // R8: write-AND status
        do_write(10'h010, 32'hFFFF_FFFF);
        chk_read(10'h010, "R8 write one keeps");
        do_write(10'h010, 32'h0);
        chk_read(10'h010, "R8 write zero clears");
        // R10 / R9: direct load and forced zero
        do_write(10'h02C, 32'h0);
        do_write(10'h024, 32'h0001_2345);
        chk_read(10'h024, "R10 load");
        do_write(10'h014, 32'h0000_0003);
        chk_read(10'h024, "R9 forced zero");
        chk_read(10'h014, "R9 event readback");
        // R4: divisor change mid-count keeps value
        do_write(10'h028, 32'h3);
        idle(9);
        do_write(10'h028, 32'h1);
        chk_read(10'h024, "R4 count kept");
        idle(5);
        chk_read(10'h024, "R4 new rate");
        // R13: stopped counter holds
        do_write(10'h000, 32'h0);
        idle(20);
        chk_read(10'h024, "R13 hold");
        // R11: unmapped writes ignored, reads zero
        for (int i = 0; i < 5; i++) begin
            do_write(holes[i], 32'hDEAD_BEEF);
            chk_read(holes[i], "R11 hole read");
        end
        for (int i = 0; i < 14; i++) chk_read(all_regs[i], "R11 no side effect");
        // Random mix
        for (int n = 0; n < 500; n++) begin
            int k = $urandom % 12;
            case (k)
                0: do_write(10'h000, ($urandom % 4 == 0) ? 32'h0 : ($urandom | 32'h1));
                1: do_write(10'h00C, $urandom);
                2: do_write(10'h010, $urandom);
                3: do_write(10'h014, $urandom % 4);
                4: do_write(10'h024, $urandom % 24);
                5: do_write(10'h028, ($urandom & 32'hFFFF_0000) | ($urandom % 4));
                6, 7: do_write(10'h02C, $urandom % 16);
                8: do_write(all_regs[7 + $urandom % 7], $urandom);
                9: do_write(holes[$urandom % 5], $urandom);
                default: idle($urandom % 8);
            endcase
            idle($urandom % 6);
            chk_read(all_regs[$urandom % 14], "R2 R5 R12 random");
            if (n % 25 == 0) chk_read(10'h010, "R7 R8 random flag");
        end
        for (int i = 7; i < 14; i++) chk_read(all_regs[i], "R12 storage");
        $display("test done: total=%0d bad=%0d", n_total, n_bad);
        $finish;
    end
endmodule